// File: doc/BRIEF.md
# SCSI Initiator Selection and Handshake Engine

This block is the host side of an 8-bit SCSI-style parallel bus. On a start request from local logic it waits until the bus is quiet. It then puts the one-hot bit of the chosen target on the data lines and raises SEL. When the target answers with BSY, the block lets go of SEL and the data lines. If no answer comes within a set number of cycles, it gives up and reports a selection timeout.

Once connected, the target leads the rest of the exchange. The three phase lines (MSG, C/D, I/O) it drives select what each REQ means. On an outbound phase the engine supplies command-descriptor bytes or data-out bytes from local logic, one per handshake, and holds each byte steady under ACK. On an inbound phase it captures the byte and parity and hands the byte to local logic as a data-in, status or message byte. It keeps a sticky flag for bad parity. When the target releases BSY with no handshake open, the engine pulses a completion strobe and becomes idle again.

All bus signals are active-high here. The bus inputs are taken to be already synchronised to `clk`. Drivers, terminations and electrical levels are outside the block.

Top module: `scsi_hs_initiator`

## Requirements
- R1: After a start pulse, the engine drives nothing onto the bus until it samples BSY, REQ, C/D, I/O and MSG all low at one clock edge. Until then, SEL and the data-line enable stay low.
- R2: The engine selects target n by enabling the data lines with only bit n set, for exactly one cycle before SEL rises. The data lines stay driven while SEL is high.
- R3: When BSY is sampled high while SEL is high, SEL and the data-line enable are both low in the next cycle.
- R4: If BSY does not appear, SEL stays high for exactly SEL_TIMEOUT cycles. SEL and the data enable then drop, and `sel_timeout_o` pulses for one cycle in the first cycle with SEL low.
- R5: On an outbound REQ the engine drives the byte for one cycle with ACK low and then raises ACK. Byte and enable are held until REQ is sampled low. ACK and the enable drop in the cycle after that sample.
- R6: Every byte the engine drives carries odd parity on `dbp_o`, so that the nine lines together hold an odd number of ones.
- R7: Phase code {MSG,C/D,I/O} selects the source or sink of each byte:
  - 010 (command) sends `cmd_byte_i`. `cmd_idx_o` starts at 0 and advances by one per command byte.
  - 000 (data-out) sends `dout_byte_i`, with `dout_idx_o` counting the same way.
  - Any other outbound code sends 0x00 and advances neither index.
  - 001 is data-in, 011 is status and 111 is message-in.
- R8: An inbound byte appears on `din_byte_o`, `status_o` or `msg_o`, matching the phase. It comes with a one-cycle valid pulse in the same cycle that ACK rises.
- R9: An inbound byte with even parity across the nine lines sets `parity_err_o`, and the byte is still delivered. The flag stays set until the next selection begins driving the bus.
- R10: When BSY is sampled low while connected and no handshake is open, `done_o` pulses for one cycle and `busy_o` falls. The next selection starts both byte indices again from 0.
- R11: During and right after reset, SEL, ACK, the data enable, `busy_o`, `done_o`, `sel_timeout_o`, `parity_err_o` and all valid strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle request to select a target (taken only while idle) |
| target_id_i | input | ID_W | Target number, sampled with `start_i` |
| cmd_byte_i | input | 8 | Command byte at index `cmd_idx_o` |
| cmd_idx_o | output | IDX_W | Index of the next command byte |
| dout_byte_i | input | 8 | Data-out byte at index `dout_idx_o` |
| dout_idx_o | output | IDX_W | Index of the next data-out byte |
| din_byte_o | output | 8 | Last data-in byte |
| din_valid_o | output | 1 | Data-in strobe |
| status_o | output | 8 | Last status byte |
| status_valid_o | output | 1 | Status strobe |
| msg_o | output | 8 | Last message-in byte |
| msg_valid_o | output | 1 | Message strobe |
| parity_err_o | output | 1 | Sticky inbound parity error |
| busy_o | output | 1 | Engine is not idle |
| done_o | output | 1 | Connection ended (BSY released) |
| sel_timeout_o | output | 1 | Selection timed out |
| bsy_i | input | 1 | Bus BSY |
| sel_o | output | 1 | Bus SEL |
| cd_i | input | 1 | Bus C/D phase line |
| io_i | input | 1 | Bus I/O phase line |
| msg_i | input | 1 | Bus MSG phase line |
| req_i | input | 1 | Bus REQ from target |
| ack_o | output | 1 | Bus ACK |
| db_i | input | 8 | Data lines as received |
| dbp_i | input | 1 | Parity line as received |
| db_o | output | 8 | Data lines to drive |
| dbp_o | output | 1 | Parity line to drive |
| db_oe_o | output | 1 | Enable for `db_o` and `dbp_o` |

## Verification
The properties assume a well-behaved target:
- It keeps REQ high until it has seen ACK.
- It holds the phase lines and inbound data steady while REQ is high.
- It raises BSY only while this engine selects it.
- It releases BSY only with REQ low.

The bench's target model follows these rules. It sets the phase lines one cycle before raising REQ, and it lowers REQ only after sampling ACK high. It drops BSY only after the final message handshake has closed. The only BSY it raises outside its own selection is a hold of the bus before selection starts, which exercises the wait for a free bus.

// File: rtl/scsi_hs_pkg.sv
// Shared types and helpers for the initiator engine.
// Phase codes are packed as {MSG, C/D, I/O}, the order the bus lines decode.
package scsi_hs_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT_FREE,
        S_DRIVE_ID,
        S_SELECT,
        S_CONNECTED
    } sel_state_t;

    typedef enum logic [1:0] {
        H_WAIT_REQ,
        H_SETUP,
        H_ACK
    } hs_state_t;

    localparam logic [2:0] PH_DOUT = 3'b000;
    localparam logic [2:0] PH_DIN  = 3'b001;
    localparam logic [2:0] PH_CMD  = 3'b010;
    localparam logic [2:0] PH_STAT = 3'b011;
    localparam logic [2:0] PH_MSGI = 3'b111;

    // Parity bit that makes byte plus parity hold an odd count of ones.
    function automatic logic odd_par(input logic [7:0] d);
        return ~(^d);
    endfunction

endpackage

// File: rtl/hs_sel_ctrl.sv
// Selection and connection controller.
// Takes a start request, waits for a quiet bus, drives the target's ID bit,
// raises SEL, and then either connects on BSY or times out.
// While connected it ends the connection once the target drops BSY with no
// handshake open.
// Assumes bus inputs are synchronous to clk and ID_W <= 3.
module hs_sel_ctrl
    import scsi_hs_pkg::*;
#(
    parameter int ID_W        = 3,
    parameter int SEL_TIMEOUT = 50000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [ID_W-1:0] target_id_i,
    input  logic            bsy_i,
    input  logic            bus_quiet_i,
    input  logic            release_ok_i,
    output logic            sel_o,
    output logic            id_drive_o,
    output logic [7:0]      id_byte_o,
    output logic            connected_o,
    output logic            sel_start_o,
    output logic            busy_o,
    output logic            sel_timeout_o,
    output logic            done_o
);

    localparam int               CNT_W    = $clog2(SEL_TIMEOUT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SEL_TIMEOUT - 1);

    sel_state_t       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [ID_W-1:0]  id_q;
    logic             timeout_q;
    logic             done_q;

    // Selection state machine with the BSY timeout counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            cnt_q     <= '0;
            id_q      <= '0;
            timeout_q <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            timeout_q <= 1'b0;
            done_q    <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        id_q    <= target_id_i;
                        state_q <= S_WAIT_FREE;
                    end
                end
                S_WAIT_FREE: begin
                    if (bus_quiet_i) state_q <= S_DRIVE_ID;
                end
                S_DRIVE_ID: begin
                    cnt_q   <= '0;
                    state_q <= S_SELECT;
                end
                S_SELECT: begin
                    if (bsy_i) begin
                        state_q <= S_CONNECTED;
                    end else if (cnt_q == CNT_LAST) begin
                        state_q   <= S_IDLE;
                        timeout_q <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                S_CONNECTED: begin
                    if (!bsy_i && release_ok_i) begin
                        state_q <= S_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Bus-facing decode of the selection state.
    always_comb begin
        id_drive_o  = (state_q == S_DRIVE_ID) || (state_q == S_SELECT);
        sel_o       = (state_q == S_SELECT);
        connected_o = (state_q == S_CONNECTED);
        busy_o      = (state_q != S_IDLE);
        sel_start_o = (state_q == S_WAIT_FREE) && bus_quiet_i;
        id_byte_o   = 8'(1) << id_q;
    end

    assign sel_timeout_o = timeout_q;
    assign done_o        = done_q;

endmodule

// File: rtl/hs_xfer.sv
// REQ/ACK handshake engine for one byte at a time.
// Inbound REQ: capture happens in the route block and ACK rises at once.
// Outbound REQ: the byte is latched, driven for one cycle, then ACK rises.
// ACK and the drive enable stay up until REQ is sampled low.
// Assumes REQ stays high until ACK is seen and the phase lines are stable
// while REQ is high.
module hs_xfer
    import scsi_hs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       active_i,
    input  logic       req_i,
    input  logic       io_i,
    input  logic [7:0] out_byte_i,
    output logic       take_in_o,
    output logic       take_out_o,
    output logic       ack_o,
    output logic       drive_o,
    output logic [7:0] db_o,
    output logic       idle_o
);

    hs_state_t  state_q;
    logic       out_q;
    logic [7:0] byte_q;

    // Acceptance of a new REQ in either direction.
    always_comb begin
        take_in_o  = active_i && (state_q == H_WAIT_REQ) && req_i && io_i;
        take_out_o = active_i && (state_q == H_WAIT_REQ) && req_i && !io_i;
    end

    // Handshake sequencing and the outbound byte latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= H_WAIT_REQ;
            out_q   <= 1'b0;
            byte_q  <= '0;
        end else begin
            case (state_q)
                H_WAIT_REQ: begin
                    if (take_in_o) begin
                        out_q   <= 1'b0;
                        state_q <= H_ACK;
                    end else if (take_out_o) begin
                        out_q   <= 1'b1;
                        byte_q  <= out_byte_i;
                        state_q <= H_SETUP;
                    end
                end
                H_SETUP: state_q <= H_ACK;
                H_ACK: begin
                    if (!req_i) begin
                        out_q   <= 1'b0;
                        state_q <= H_WAIT_REQ;
                    end
                end
                default: state_q <= H_WAIT_REQ;
            endcase
        end
    end

    // Output decode of the handshake state.
    always_comb begin
        ack_o   = (state_q == H_ACK);
        drive_o = (state_q == H_SETUP) || ((state_q == H_ACK) && out_q);
        idle_o  = (state_q == H_WAIT_REQ);
        db_o    = byte_q;
    end

endmodule

// File: rtl/hs_phase_route.sv
// Routes bytes by bus phase.
// Outbound: selects the command, data-out or zero byte and advances the
// matching index.
// Inbound: stores data-in, status or message bytes with a strobe and keeps a
// sticky parity error.
// Assumes take strobes come from hs_xfer and clear_i marks a new selection.
module hs_phase_route
    import scsi_hs_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [2:0]       phase_i,
    input  logic [7:0]       db_i,
    input  logic             dbp_i,
    input  logic             take_in_i,
    input  logic             take_out_i,
    input  logic [7:0]       cmd_byte_i,
    input  logic [7:0]       dout_byte_i,
    output logic [7:0]       out_byte_o,
    output logic [IDX_W-1:0] cmd_idx_o,
    output logic [IDX_W-1:0] dout_idx_o,
    output logic [7:0]       din_byte_o,
    output logic             din_valid_o,
    output logic [7:0]       status_o,
    output logic             status_valid_o,
    output logic [7:0]       msg_o,
    output logic             msg_valid_o,
    output logic             parity_err_o
);

    logic par_bad;

    // Outbound byte selection by phase.
    always_comb begin
        case (phase_i)
            PH_CMD:  out_byte_o = cmd_byte_i;
            PH_DOUT: out_byte_o = dout_byte_i;
            default: out_byte_o = 8'h00;
        endcase
        par_bad = (^{db_i, dbp_i}) == 1'b0;
    end

    // Outbound index counters, restarted at each selection.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cmd_idx_o  <= '0;
            dout_idx_o <= '0;
        end else if (take_out_i) begin
            if (phase_i == PH_CMD)  cmd_idx_o  <= cmd_idx_o + IDX_W'(1);
            if (phase_i == PH_DOUT) dout_idx_o <= dout_idx_o + IDX_W'(1);
        end
    end

    // Inbound capture with strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            din_byte_o     <= '0;
            status_o       <= '0;
            msg_o          <= '0;
            din_valid_o    <= 1'b0;
            status_valid_o <= 1'b0;
            msg_valid_o    <= 1'b0;
        end else begin
            din_valid_o    <= 1'b0;
            status_valid_o <= 1'b0;
            msg_valid_o    <= 1'b0;
            if (take_in_i) begin
                case (phase_i)
                    PH_DIN: begin
                        din_byte_o  <= db_i;
                        din_valid_o <= 1'b1;
                    end
                    PH_STAT: begin
                        status_o       <= db_i;
                        status_valid_o <= 1'b1;
                    end
                    PH_MSGI: begin
                        msg_o       <= db_i;
                        msg_valid_o <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Sticky parity flag, cleared when a new selection starts.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            parity_err_o <= 1'b0;
        end else if (take_in_i && par_bad) begin
            parity_err_o <= 1'b1;
        end
    end

endmodule

// File: rtl/scsi_hs_initiator.sv
// Top of the initiator engine.
// Joins the selection controller, the handshake engine and the phase router,
// and merges the two data-line drivers with odd parity.
// Assumes all bus inputs are active-high and already synchronised to clk.
module scsi_hs_initiator
    import scsi_hs_pkg::*;
#(
    parameter int ID_W        = 3,
    parameter int SEL_TIMEOUT = 50000,
    parameter int IDX_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [ID_W-1:0]  target_id_i,
    input  logic [7:0]       cmd_byte_i,
    output logic [IDX_W-1:0] cmd_idx_o,
    input  logic [7:0]       dout_byte_i,
    output logic [IDX_W-1:0] dout_idx_o,
    output logic [7:0]       din_byte_o,
    output logic             din_valid_o,
    output logic [7:0]       status_o,
    output logic             status_valid_o,
    output logic [7:0]       msg_o,
    output logic             msg_valid_o,
    output logic             parity_err_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             sel_timeout_o,
    input  logic             bsy_i,
    output logic             sel_o,
    input  logic             cd_i,
    input  logic             io_i,
    input  logic             msg_i,
    input  logic             req_i,
    output logic             ack_o,
    input  logic [7:0]       db_i,
    input  logic             dbp_i,
    output logic [7:0]       db_o,
    output logic             dbp_o,
    output logic             db_oe_o
);

    logic       bus_quiet;
    logic       id_drive;
    logic [7:0] id_byte;
    logic       connected;
    logic       sel_start;
    logic       xfer_idle;
    logic       take_in;
    logic       take_out;
    logic       xfer_drive;
    logic [7:0] xfer_byte;
    logic [7:0] out_byte;
    logic [2:0] phase;

    // Bus-free test and phase code assembly.
    always_comb begin
        bus_quiet = !bsy_i && !req_i && !cd_i && !io_i && !msg_i;
        phase     = {msg_i, cd_i, io_i};
    end

    hs_sel_ctrl #(
        .ID_W        (ID_W),
        .SEL_TIMEOUT (SEL_TIMEOUT)
    ) sel_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .target_id_i   (target_id_i),
        .bsy_i         (bsy_i),
        .bus_quiet_i   (bus_quiet),
        .release_ok_i  (xfer_idle),
        .sel_o         (sel_o),
        .id_drive_o    (id_drive),
        .id_byte_o     (id_byte),
        .connected_o   (connected),
        .sel_start_o   (sel_start),
        .busy_o        (busy_o),
        .sel_timeout_o (sel_timeout_o),
        .done_o        (done_o)
    );

    hs_xfer xfer_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (connected),
        .req_i      (req_i),
        .io_i       (io_i),
        .out_byte_i (out_byte),
        .take_in_o  (take_in),
        .take_out_o (take_out),
        .ack_o      (ack_o),
        .drive_o    (xfer_drive),
        .db_o       (xfer_byte),
        .idle_o     (xfer_idle)
    );

    hs_phase_route #(
        .IDX_W (IDX_W)
    ) route_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .clear_i        (sel_start),
        .phase_i        (phase),
        .db_i           (db_i),
        .dbp_i          (dbp_i),
        .take_in_i      (take_in),
        .take_out_i     (take_out),
        .cmd_byte_i     (cmd_byte_i),
        .dout_byte_i    (dout_byte_i),
        .out_byte_o     (out_byte),
        .cmd_idx_o      (cmd_idx_o),
        .dout_idx_o     (dout_idx_o),
        .din_byte_o     (din_byte_o),
        .din_valid_o    (din_valid_o),
        .status_o       (status_o),
        .status_valid_o (status_valid_o),
        .msg_o          (msg_o),
        .msg_valid_o    (msg_valid_o),
        .parity_err_o   (parity_err_o)
    );

    // Merge of the ID driver and the handshake driver, plus parity.
    always_comb begin
        db_oe_o = id_drive || xfer_drive;
        db_o    = id_drive ? id_byte : (xfer_drive ? xfer_byte : 8'h00);
        dbp_o   = odd_par(db_o);
    end

endmodule

// File: rtl/hs_initiator_chk.sv
// Protocol checker for scsi_hs_initiator, attached by bind.
// Assumes a target that holds REQ until ACK and raises BSY only when selected.
module hs_initiator_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sel_o,
    input logic       db_oe_o,
    input logic [7:0] db_o,
    input logic       ack_o,
    input logic       req_i,
    input logic       bsy_i,
    input logic       cd_i,
    input logic       io_i,
    input logic       msg_i,
    input logic       sel_timeout_o,
    input logic       din_valid_o,
    input logic       id_drive,
    input logic       connected
);

    // R1: ID drive starts only after a quiet bus was sampled.
    a_r1_quiet_before_id: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(id_drive) |-> $past(!bsy_i && !req_i && !cd_i && !io_i && !msg_i));

    // R2: the data lines were already driven in the cycle before SEL rose.
    a_r2_id_before_sel: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_o) |-> ($past(db_oe_o) && db_oe_o));

    // R3: BSY during SEL releases SEL and the data lines next cycle.
    a_r3_release_on_bsy: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o && bsy_i) |=> (!sel_o && !db_oe_o));

    // R4: a timeout leaves the bus released.
    a_r4_timeout_released: assert property (@(posedge clk) disable iff (!rst_n)
        sel_timeout_o |-> (!sel_o && !db_oe_o));

    // R5: ACK stays up while REQ is still high.
    a_r5_ack_waits_req: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && req_i) |=> ack_o);

    // R5: outbound data was on the bus a cycle before ACK rose.
    a_r5_setup_before_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ack_o) && db_oe_o) |-> $past(db_oe_o));

    // R5: outbound data stays put while REQ is high under ACK.
    a_r5_hold_under_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o && db_oe_o && req_i) |=> (db_oe_o && $stable(db_o)));

    // R8: a data-in strobe coincides with ACK high.
    a_r8_strobe_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        din_valid_o |-> ack_o);

    // R10: no ACK outside a connection.
    a_r10_no_ack_unconnected: assert property (@(posedge clk) disable iff (!rst_n)
        !connected |-> !ack_o);

endmodule

bind scsi_hs_initiator hs_initiator_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .sel_o         (sel_o),
    .db_oe_o       (db_oe_o),
    .db_o          (db_o),
    .ack_o         (ack_o),
    .req_i         (req_i),
    .bsy_i         (bsy_i),
    .cd_i          (cd_i),
    .io_i          (io_i),
    .msg_i         (msg_i),
    .sel_timeout_o (sel_timeout_o),
    .din_valid_o   (din_valid_o),
    .id_drive      (id_drive),
    .connected     (connected)
);

// File: tb/scsi_hs_initiator_tb.sv
`timescale 1ns/1ps
// Bench: a target model walks a table of phase/byte vectors, then directed
// tests cover reset, wait-for-free, timeout and restart.
module scsi_hs_initiator_tb_top;

    localparam int TMO = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [2:0] target_id_i = '0;
    logic [7:0] cmd_byte_i, dout_byte_i;
    logic [7:0] cmd_idx_o, dout_idx_o;
    logic [7:0] din_byte_o, status_o, msg_o;
    logic       din_valid_o, status_valid_o, msg_valid_o;
    logic       parity_err_o, busy_o, done_o, sel_timeout_o;
    logic       bsy_i = 1'b0, cd_i = 1'b0, io_i = 1'b0, msg_i = 1'b0, req_i = 1'b0;
    logic       sel_o, ack_o;
    logic [7:0] db_i = '0;
    logic       dbp_i = 1'b1;
    logic [7:0] db_o;
    logic       dbp_o, db_oe_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    // Local side: command bytes C0+i, data-out bytes 5A+i.
    assign cmd_byte_i  = 8'hC0 + cmd_idx_o;
    assign dout_byte_i = 8'h5A + dout_idx_o;

    scsi_hs_initiator #(.ID_W(3), .SEL_TIMEOUT(TMO), .IDX_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .target_id_i(target_id_i),
        .cmd_byte_i(cmd_byte_i), .cmd_idx_o(cmd_idx_o),
        .dout_byte_i(dout_byte_i), .dout_idx_o(dout_idx_o),
        .din_byte_o(din_byte_o), .din_valid_o(din_valid_o),
        .status_o(status_o), .status_valid_o(status_valid_o),
        .msg_o(msg_o), .msg_valid_o(msg_valid_o),
        .parity_err_o(parity_err_o), .busy_o(busy_o), .done_o(done_o),
        .sel_timeout_o(sel_timeout_o), .bsy_i(bsy_i), .sel_o(sel_o),
        .cd_i(cd_i), .io_i(io_i), .msg_i(msg_i), .req_i(req_i), .ack_o(ack_o),
        .db_i(db_i), .dbp_i(dbp_i), .db_o(db_o), .dbp_o(dbp_o), .db_oe_o(db_oe_o)
    );

    // Vector layout: {phase[2:0], bad_parity, target_byte[7:0], expected[7:0]}
    localparam int NV = 14;
    localparam logic [19:0] VEC [0:NV-1] = '{
        {3'b010, 1'b0, 8'h00, 8'hC0},
        {3'b010, 1'b0, 8'h00, 8'hC1},
        {3'b010, 1'b0, 8'h00, 8'hC2},
        {3'b010, 1'b0, 8'h00, 8'hC3},
        {3'b010, 1'b0, 8'h00, 8'hC4},
        {3'b010, 1'b0, 8'h00, 8'hC5},
        {3'b001, 1'b0, 8'h11, 8'h11},
        {3'b001, 1'b1, 8'hA5, 8'hA5},
        {3'b001, 1'b0, 8'h00, 8'h00},
        {3'b000, 1'b0, 8'h00, 8'h5A},
        {3'b000, 1'b0, 8'h00, 8'h5B},
        {3'b110, 1'b0, 8'h00, 8'h00},
        {3'b011, 1'b0, 8'h02, 8'h02},
        {3'b111, 1'b0, 8'h00, 8'h00}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Poll at falling edges until ack_o equals lvl; prev_oe is the enable one cycle earlier.
    task automatic wait_ack(input logic lvl, output bit ok, output logic prev_oe);
        ok = 1'b0;
        prev_oe = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (ack_o === lvl) begin
                ok = 1'b1;
                break;
            end
            prev_oe = db_oe_o;
        end
    endtask

    task automatic pulse_start(input logic [2:0] id);
        @(negedge clk);
        target_id_i = id;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Selects target id; checks R2 along the way, then answers with BSY and checks R3.
    task automatic select_target(input logic [2:0] id);
        bit seen;
        logic [7:0] idb;
        idb = 8'(1) << id;
        seen = 1'b0;
        pulse_start(id);
        for (int i = 0; i < 10 && !seen; i++) begin
            if (db_oe_o === 1'b1) seen = 1'b1;
            else @(negedge clk);
        end
        check(seen && sel_o === 1'b0 && db_o === idb && dbp_o === ~^idb,
              "R2 id before sel", {sel_o, db_o}, {1'b0, idb});
        @(negedge clk);
        check(sel_o === 1'b1 && db_oe_o === 1'b1 && db_o === idb,
              "R2 sel with id", {sel_o, db_oe_o, db_o}, {2'b11, idb});
        bsy_i = 1'b1;
        @(negedge clk);
        check(sel_o === 1'b0 && db_oe_o === 1'b0, "R3 release on bsy",
              {sel_o, db_oe_o}, 0);
    endtask

    // One target-led handshake from the vector table.
    task automatic run_vec(input logic [19:0] v);
        logic [2:0] ph;
        logic bad, prev_oe;
        logic [7:0] tb_byte, exp;
        bit ok;
        ph = v[19:17]; bad = v[16]; tb_byte = v[15:8]; exp = v[7:0];
        {msg_i, cd_i, io_i} = ph;
        db_i = tb_byte;
        dbp_i = bad ? ^tb_byte : ~^tb_byte;
        @(negedge clk);
        req_i = 1'b1;
        wait_ack(1'b1, ok, prev_oe);
        if (!ph[0]) begin
            // R5, R6, R7: outbound byte, parity, setup cycle before ACK
            check(ok && prev_oe === 1'b1 && db_oe_o === 1'b1 && db_o === exp && dbp_o === ~^exp,
                  "R7 outbound byte (R5 setup, R6 parity)", {prev_oe, db_oe_o, db_o}, {2'b11, exp});
        end else if (ph == 3'b001) begin
            check(ok && din_valid_o === 1'b1 && din_byte_o === exp, "R8 data-in strobe",
                  {din_valid_o, din_byte_o}, {1'b1, exp});
        end else if (ph == 3'b011) begin
            check(ok && status_valid_o === 1'b1 && status_o === exp, "R8 status strobe",
                  {status_valid_o, status_o}, {1'b1, exp});
        end else begin
            check(ok && msg_valid_o === 1'b1 && msg_o === exp, "R8 message strobe",
                  {msg_valid_o, msg_o}, {1'b1, exp});
        end
        @(negedge clk);
        @(negedge clk);
        // R5: still holding while REQ high
        if (!ph[0])
            check(ack_o === 1'b1 && db_oe_o === 1'b1 && db_o === exp, "R5 hold under ack",
                  {ack_o, db_oe_o, db_o}, {2'b11, exp});
        req_i = 1'b0;
        @(negedge clk);
        check(ack_o === 1'b0 && db_oe_o === 1'b0, "R5 ack drops after req low",
              {ack_o, db_oe_o}, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        bit got;
        int hi;
        // R11: reset state
        repeat (4) @(negedge clk);
        check(sel_o === 1'b0 && ack_o === 1'b0 && db_oe_o === 1'b0 && busy_o === 1'b0,
              "R11 reset bus outputs", {sel_o, ack_o, db_oe_o, busy_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done_o === 1'b0 && sel_timeout_o === 1'b0 && parity_err_o === 1'b0 &&
              din_valid_o === 1'b0 && status_valid_o === 1'b0 && msg_valid_o === 1'b0,
              "R11 reset flags", {done_o, sel_timeout_o, parity_err_o}, 0);

        // R4: no answer, count SEL cycles
        pulse_start(3'd3);
        hi = 0;
        got = 1'b0;
        for (int i = 0; i < 4 * TMO; i++) begin
            if (sel_o === 1'b1) hi++;
            else if (hi > 0) begin
                got = (sel_timeout_o === 1'b1) && (db_oe_o === 1'b0);
                break;
            end
            @(negedge clk);
        end
        check(hi == TMO, "R4 sel duration", hi, TMO);
        check(got, "R4 timeout pulse and release", got, 1);

        // R1: a busy bus blocks selection
        bsy_i = 1'b1;
        pulse_start(3'd5);
        got = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (sel_o !== 1'b0 || db_oe_o !== 1'b0) got = 1'b0;
        end
        check(got, "R1 wait while bsy", {sel_o, db_oe_o}, 0);
        bsy_i = 1'b0;

        // Selection continues once free (R2, R3 inside)
        begin
            logic [7:0] idb;
            idb = 8'h20;
            got = 1'b0;
            for (int i = 0; i < 10 && !got; i++) begin
                @(negedge clk);
                if (db_oe_o === 1'b1) got = 1'b1;
            end
            check(got && sel_o === 1'b0 && db_o === idb, "R1 R2 id after bus frees",
                  {sel_o, db_o}, idb);
            @(negedge clk);
            check(sel_o === 1'b1 && db_o === idb && dbp_o === ~^idb, "R2 R6 sel with id",
                  {sel_o, db_o}, {1'b1, idb});
            bsy_i = 1'b1;
            @(negedge clk);
            check(sel_o === 1'b0 && db_oe_o === 1'b0, "R3 release on bsy", {sel_o, db_oe_o}, 0);
        end

        // Table walk: command, data-in, data-out, other code, status, message
        for (int k = 0; k < NV; k++) begin
            run_vec(VEC[k]);
            if (k == 6) check(parity_err_o === 1'b0, "R9 flag clear before bad byte", parity_err_o, 0);
            if (k == 7) check(parity_err_o === 1'b1 && din_byte_o === 8'hA5,
                              "R9 flag set, byte kept", {parity_err_o, din_byte_o}, 9'h1A5);
            if (k == 11) check(cmd_idx_o === 8'd6 && dout_idx_o === 8'd2,
                               "R7 other code leaves indices", {cmd_idx_o, dout_idx_o}, 16'h0602);
        end

        // R10: target releases the bus
        @(negedge clk);
        {msg_i, cd_i, io_i} = 3'b000;
        bsy_i = 1'b0;
        @(negedge clk);
        check(done_o === 1'b1 && busy_o === 1'b0, "R10 done on bsy release",
              {done_o, busy_o}, 2'b10);
        @(negedge clk);
        check(done_o === 1'b0, "R10 done is one pulse", done_o, 0);

        // R9, R10: next selection clears flag and restarts indices
        select_target(3'd0);
        check(parity_err_o === 1'b0 && cmd_idx_o === 8'd0, "R9 R10 cleared at new selection",
              {parity_err_o, cmd_idx_o}, 0);
        run_vec({3'b010, 1'b0, 8'h00, 8'hC0});
        @(negedge clk);
        {msg_i, cd_i, io_i} = 3'b000;
        bsy_i = 1'b0;
        @(negedge clk);
        check(done_o === 1'b1, "R10 second connection ends", done_o, 1);

        repeat (3) @(negedge clk);
        report();
    end

endmodule